// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two `WIDTH`-bit operands one multiplier bit at a time. It is meant for fabrics built only from lookup tables, where a full combinational array multiplier would cost too much area. It gives up latency to save that area. A result takes `WIDTH + 2` clock cycles and the unit holds only one operation at a time. The datapath has one `WIDTH`-bit adder and one `2*WIDTH`-bit accumulator. The adder always writes the upper half of the accumulator. The multiplier operand sits in the lower half and is used up from the bottom, one bit per step. The product bits take its place as they shift down.

A requester presents both operands with `startValid` while `busy` is low. When the result is ready, `doneValid` rises for one cycle and `product` carries the full double-width result. `product` then holds that value until a later operation completes. The parameter `SIGNED_MODE` selects two's-complement operands instead of unsigned ones. That mode costs extra logic, so it is off by default.

Top module: `mul_shift_add`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy` is 0, `doneValid` is 0 and `product` is all zeros.
- R2: Suppose `startValid` is high at a rising edge while `busy` is low. Then `busy` is 1 for exactly the next `WIDTH + 1` cycles and then returns to 0.
- R3: `doneValid` is 1 for exactly one cycle. That cycle starts `WIDTH + 1` edges after the edge that accepted the operation, and it is the first cycle in which `busy` is low again.
- R4: With `SIGNED_MODE = 0`, `product` in the done cycle equals `opA * opB` as unsigned numbers, with all `2*WIDTH` bits kept. This includes the carry out of the top bit, for example all-ones times all-ones.
- R5: `startValid`, `opA` and `opB` have no effect while `busy` is 1. The result reported is the one for the operands captured at the accepting edge.
- R6: `product` changes only at the edge that raises `doneValid`. It keeps its value in every other cycle.
- R7: With `SIGNED_MODE = 1`, `product` in the done cycle equals the two's-complement product of `opA` and `opB`, taken as a `2*WIDTH`-bit signed value. This includes the most negative operand on either side.
- R8: A start that is presented during the done cycle is accepted, so `busy` is 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Request for a new multiply; accepted only while `busy` is low |
| opA | input | WIDTH | Multiplicand, captured at the accepting edge |
| opB | input | WIDTH | Multiplier, captured at the accepting edge |
| busy | output | 1 | High while an accepted operation is in progress |
| doneValid | output | 1 | One-cycle pulse marking a fresh result |
| product | output | 2*WIDTH | Result of the last completed multiply |

## Verification
The hardest cases to reach from the ports are those where a new request arrives while the unit is already working, or arrives in the one done cycle. The bench drives those cases on purpose. It raises `startValid` with different operands in the middle of an operation, and it fires a new start in the same cycle as the done pulse. A bench-side model that counts cycles then shows that the request inside the operation was dropped and the one in the done cycle was taken. The carry-out path and the final subtract in signed mode depend only on operand values. Directed all-ones, zero and most-negative operands reach them, and two instances, one unsigned and one signed, see the same stimulus.

// File: rtl/mul_pkg.sv
package mul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STEP   = 2'd1,
    ST_FINISH = 2'd2
  } mulState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture operands, clear upper half
    logic step;      // one add-and-shift
    logic lastStep;  // current step consumes the multiplier's top bit
    logic capture;   // copy accumulator to the result register
  } mulCtl_t;

endpackage

// File: rtl/mul_addsub.sv
module mul_addsub #(
  parameter int WIDTH       = 8,
  parameter bit SIGNED_MODE = 1'b0
) (
  input  logic [WIDTH-1:0] upper,
  input  logic [WIDTH-1:0] addend,
  input  logic             useAddend,
  input  logic             subtract,
  output logic [WIDTH:0]   sum
);

  logic extUpper;
  logic extAddend;

  generate
    if (SIGNED_MODE) begin : g_signedExt
      assign extUpper  = upper[WIDTH-1];
      assign extAddend = addend[WIDTH-1];
    end else begin : g_zeroExt
      assign extUpper  = 1'b0;
      assign extAddend = 1'b0;
    end
  endgenerate

  logic [WIDTH:0] upperX;
  logic [WIDTH:0] addX;

  always_comb begin
    upperX = {extUpper, upper};
    addX   = useAddend ? {extAddend, addend} : '0;
    if (subtract) sum = upperX - addX;
    else          sum = upperX + addX;
  end

endmodule

// File: rtl/mul_datapath.sv
module mul_datapath
  import mul_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter bit SIGNED_MODE = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  mulCtl_t            ctl,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic [2*WIDTH-1:0] result
);

  localparam int PW = 2 * WIDTH;

  logic [PW-1:0]    acc;
  logic [WIDTH-1:0] mcand;
  logic [PW-1:0]    resultQ;
  logic [WIDTH:0]   stepSum;
  logic             doSub;

  // the final step subtracts only in signed mode
  assign doSub = SIGNED_MODE ? ctl.lastStep : 1'b0;

  mul_addsub #(
    .WIDTH      (WIDTH),
    .SIGNED_MODE(SIGNED_MODE)
  ) u_addsub (
    .upper    (acc[PW-1:WIDTH]),
    .addend   (mcand),
    .useAddend(acc[0]),
    .subtract (doSub),
    .sum      (stepSum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      mcand   <= '0;
      resultQ <= '0;
    end else begin
      if (ctl.load) begin
        acc   <= {{WIDTH{1'b0}}, opB};
        mcand <= opA;
      end else if (ctl.step) begin
        // sum's extra bit becomes the new top bit; multiplier bit 0 drops out
        acc <= {stepSum, acc[WIDTH-1:1]};
      end
      if (ctl.capture) resultQ <= acc;
    end
  end

  assign result = resultQ;

endmodule

// File: rtl/mul_control.sv
module mul_control
  import mul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    startValid,
  output mulCtl_t ctl,
  output logic    busy,
  output logic    doneValid
);

  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(WIDTH - 1);

  mulState_e        state;
  logic [CNT_W-1:0] stepCnt;
  logic             doneQ;

  always_comb begin
    ctl          = '0;
    ctl.load     = (state == ST_IDLE) && startValid;
    ctl.step     = (state == ST_STEP);
    ctl.lastStep = (state == ST_STEP) && (stepCnt == LAST_CNT);
    ctl.capture  = (state == ST_FINISH);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      doneQ   <= 1'b0;
    end else begin
      doneQ <= (state == ST_FINISH);
      unique case (state)
        ST_IDLE: begin
          if (startValid) begin
            state   <= ST_STEP;
            stepCnt <= '0;
          end
        end
        ST_STEP: begin
          if (stepCnt == LAST_CNT) state <= ST_FINISH;
          else                     stepCnt <= stepCnt + 1'b1;
        end
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign doneValid = doneQ;

endmodule

// File: rtl/mul_shift_add.sv
module mul_shift_add
  import mul_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter bit SIGNED_MODE = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               startValid,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  output logic               busy,
  output logic               doneValid,
  output logic [2*WIDTH-1:0] product
);

  mulCtl_t ctl;

  mul_control #(
    .WIDTH(WIDTH)
  ) u_control (
    .clk       (clk),
    .rst_n     (rst_n),
    .startValid(startValid),
    .ctl       (ctl),
    .busy      (busy),
    .doneValid (doneValid)
  );

  mul_datapath #(
    .WIDTH      (WIDTH),
    .SIGNED_MODE(SIGNED_MODE)
  ) u_datapath (
    .clk   (clk),
    .rst_n (rst_n),
    .ctl   (ctl),
    .opA   (opA),
    .opB   (opB),
    .result(product)
  );

endmodule

// File: rtl/mul_shift_add_chk.sv
module mul_shift_add_chk #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               startValid,
  input logic               busy,
  input logic               doneValid,
  input logic [2*WIDTH-1:0] product
);

  int busyRun;

  always_ff @(posedge clk) begin
    if (!rst_n)    busyRun <= 0;
    else if (busy) busyRun <= busyRun + 1;
    else           busyRun <= 0;
  end

  // R2
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busyRun == WIDTH + 1));

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(startValid));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |=> !doneValid);

  // R3
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> doneValid);

  // R6
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !doneValid |-> $stable(product));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doneValid && startValid) |=> busy);

endmodule

bind mul_shift_add mul_shift_add_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .startValid(startValid),
  .busy      (busy),
  .doneValid (doneValid),
  .product   (product)
);

// File: tb/mul_shift_add_tb.sv
module mul_shift_add_tb;

  localparam int N  = 8;
  localparam int PW = 2 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          startValid = 1'b0;
  logic [N-1:0]  opA = '0;
  logic [N-1:0]  opB = '0;
  logic          busyU, doneU, busyS, doneS;
  logic [PW-1:0] prodU, prodS;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  mul_shift_add #(.WIDTH(N), .SIGNED_MODE(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .startValid(startValid), .opA(opA), .opB(opB),
    .busy(busyU), .doneValid(doneU), .product(prodU));

  mul_shift_add #(.WIDTH(N), .SIGNED_MODE(1'b1)) u_dutS (
    .clk(clk), .rst_n(rst_n), .startValid(startValid), .opA(opA), .opB(opB),
    .busy(busyS), .doneValid(doneS), .product(prodS));

  function automatic logic [PW-1:0] mulU(logic [N-1:0] a, logic [N-1:0] b);
    logic [PW-1:0] x, y;
    x = {{N{1'b0}}, a};
    y = {{N{1'b0}}, b};
    return x * y;
  endfunction

  function automatic logic [PW-1:0] mulS(logic [N-1:0] a, logic [N-1:0] b);
    longint x, y;
    x = longint'($signed(a));
    y = longint'($signed(b));
    return PW'(x * y);
  endfunction

  // behavioural cycle model
  int            mPhase = 0;
  logic          mBusy = 1'b0, mDone = 1'b0;
  logic [PW-1:0] mPendU = '0, mPendS = '0, mOutU = '0, mOutS = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mPhase <= 0; mBusy <= 1'b0; mDone <= 1'b0; mOutU <= '0; mOutS <= '0;
    end else begin
      mDone <= 1'b0;
      if (mPhase == 0) begin
        if (startValid) begin
          mPhase <= 1; mBusy <= 1'b1;
          mPendU <= mulU(opA, opB); mPendS <= mulS(opA, opB);
        end
      end else if (mPhase <= N) begin
        mPhase <= mPhase + 1;
      end else begin
        mPhase <= 0; mBusy <= 1'b0; mDone <= 1'b1;
        mOutU <= mPendU; mOutS <= mPendS;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!finished) begin
      check(busyU == mBusy, "R2 busy (unsigned)", PW'(busyU), PW'(mBusy));
      check(busyS == mBusy, "R2 busy (signed)", PW'(busyS), PW'(mBusy));
      check(doneU == mDone, "R3 done (unsigned)", PW'(doneU), PW'(mDone));
      check(doneS == mDone, "R3 done (signed)", PW'(doneS), PW'(mDone));
      check(prodU == mOutU, "R4/R6 product (unsigned)", prodU, mOutU);
      check(prodS == mOutS, "R7/R6 product (signed)", prodS, mOutS);
    end
  end

  task automatic waitDone();
    while (!doneU) @(negedge clk);
  endtask

  task automatic runOp(input logic [N-1:0] a, input logic [N-1:0] b);
    while (busyU) @(negedge clk);
    startValid = 1'b1; opA = a; opB = b;
    @(negedge clk);
    startValid = 1'b0;
    waitDone();
    check(prodU == mulU(a, b), "R4 unsigned product", prodU, mulU(a, b));
    check(prodS == mulS(a, b), "R7 signed product", prodS, mulS(a, b));
  endtask

  initial begin
    logic [PW-1:0] held;
    repeat (3) @(negedge clk);
    // R1 during reset
    check(busyU == 1'b0 && doneU == 1'b0, "R1 reset outputs", {busyU, doneU}, '0);
    check(prodU == '0 && prodS == '0, "R1 reset product", prodU | prodS, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busyU == 1'b0 && prodU == '0, "R1 after reset", prodU, '0);

    // corner operands
    runOp('0, '0);
    runOp('1, '1);
    runOp('1, '0);
    runOp(8'h80, 8'h80);
    runOp(8'h80, 8'h7F);
    runOp(8'h7F, 8'h80);
    runOp(8'h01, '1);
    runOp('1, 8'h01);

    // R5: new request and new operands while busy
    while (busyU) @(negedge clk);
    startValid = 1'b1; opA = 8'd3; opB = 8'd5;
    @(negedge clk);
    opA = 8'd200; opB = 8'd199;
    repeat (3) @(negedge clk);
    startValid = 1'b0;
    waitDone();
    check(prodU == 16'd15, "R5 ignored start while busy (unsigned)", prodU, 16'd15);
    check(prodS == 16'd15, "R5 ignored start while busy (signed)", prodS, 16'd15);

    // R6: product held while idle with operands moving
    held = prodU;
    for (int i = 0; i < 6; i++) begin
      opA = N'($urandom); opB = N'($urandom);
      @(negedge clk);
    end
    check(prodU == held, "R6 product held while idle", prodU, held);

    // R8: start in the done cycle
    while (busyU) @(negedge clk);
    startValid = 1'b1; opA = 8'd9; opB = 8'd11;
    @(negedge clk);
    startValid = 1'b0;
    waitDone();
    startValid = 1'b1; opA = 8'hF0; opB = 8'h0F;
    @(negedge clk);
    startValid = 1'b0;
    check(busyU == 1'b1, "R8 start accepted in done cycle", PW'(busyU), PW'(1));
    waitDone();
    check(prodU == mulU(8'hF0, 8'h0F), "R8 result of done-cycle start",
          prodU, mulU(8'hF0, 8'h0F));

    // random operands
    for (int i = 0; i < 60; i++) runOp(N'($urandom), N'($urandom));

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule